// File: doc/BRIEF.md
# Status-Store Parameter Validator

This block screens the operand of three inter-processor orders before any memory traffic is started: storing a processor's status at a given address, storing extended status into a save area of selectable size, and moving a target processor's prefix area. Each order arrives with a 64-bit operand. The block derives the effective address and area length from that operand. It then checks the target's stopped flag, the presence of the two optional features, the alignment of the area, and the memory side's verdict on the range.

When every check passes, it raises a one-cycle request strobe together with the address and length. When a check fails, it instead returns the code of the first failed rule, which the caller then stores as the order's status. All results are registered and appear one clock after the inputs are presented.

Top module: `status_param_check`

## Requirements
- R1: `res_valid` pulses high exactly one cycle after each cycle in which `in_valid` is high, and is low one cycle after a cycle with `in_valid` low.
- R2: For order code 0 (store status at address), `res_addr` is the operand ANDed with 0x7FFFFE00 and `res_len` is 512.
- R3: For order 0, a target that is not stopped gives status 2 (incorrect state). For a stopped target, `mem_ok` low gives status 3 (invalid parameter), and otherwise status 0 (accepted). For order 1, `mem_ok` low after all other checks pass gives status 3.
- R4: For order code 1 (store extended status), the length code is operand bits [3:0]. `res_addr` is the operand with those four bits cleared. `res_len` is 2^code, or 1024 when the code is 0.
- R5: Order 1 with both `feat_vec` and `feat_gs` low gives status 1 (invalid order), whatever the stopped flag.
- R6: Order 1 with a feature present and a target that is not stopped gives status 2.
- R7: Order 1 on a stopped target whose address is not a multiple of the length gives status 3.
- R8: For order 1, with `feat_gs` low only length code 0 is legal; with `feat_gs` high, codes 0, 10, 11 and 12 are legal. Any other code gives status 3 once the earlier checks pass.
- R9: For order code 2 (set prefix), `res_addr` is the operand ANDed with 0x7FFFE000 and `res_len` is 8192. `mem_ok` low gives status 3 even when the target is not stopped; otherwise a target that is not stopped gives status 2, and a stopped one gives status 0.
- R10: `res_req` is high only in a `res_valid` cycle whose status is 0. Order code 3 gives status 1 and no request.
- R11: During reset, `res_valid`, `res_req`, `res_status`, `res_addr` and `res_len` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Inputs carry an order this cycle |
| in_order | input | 2 | Order code: 0 store at address, 1 extended status, 2 set prefix, 3 unused |
| in_param | input | 64 | Order operand |
| tgt_stopped | input | 1 | Target processor is stopped |
| feat_vec | input | 1 | Vector feature installed |
| feat_gs | input | 1 | Guarded-storage feature installed |
| mem_ok | input | 1 | Memory side accepts the effective range |
| res_valid | output | 1 | Result present |
| res_status | output | 2 | 0 accepted, 1 invalid order, 2 incorrect state, 3 invalid parameter |
| res_addr | output | 64 | Effective address |
| res_len | output | 16 | Area length in bytes |
| res_req | output | 1 | Store or prefix-update request strobe |

## Verification
Every result (valid, status, address, length and request) is due one clock after the inputs that caused it. So the bench drives an order on a falling edge and compares the outputs on the next falling edge, after the single register stage has loaded. After an idle cycle, the bench confirms that valid and request have dropped. Directed orders hit each rule in its precedence slot, and seeded random operands with biased length codes and alignment cover the rest.

// File: rtl/spc_pkg.sv
// Shared encodings for the status-store parameter validator.
// Assumes order and status codes are 2 bits wide at the block edge.
package spc_pkg;
    typedef enum logic [1:0] {
        OP_STORE_AT    = 2'd0,
        OP_STORE_EXTRA = 2'd1,
        OP_SET_PFX     = 2'd2,
        OP_RSVD        = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_ACCEPT    = 2'd0,
        ST_BAD_ORDER = 2'd1,
        ST_BAD_STATE = 2'd2,
        ST_BAD_PARAM = 2'd3
    } st_e;
endpackage

// File: rtl/spc_addr_gen.sv
// Derives effective address, area length and a misalignment flag from the
// operand. Assumes ADDR_TOP < PARAM_W and every log2 length fits LEN_W bits.
module spc_addr_gen #(
    parameter int PARAM_W  = 64,
    parameter int LEN_W    = 16,
    parameter int ADDR_TOP = 31,
    parameter int STS_LG   = 9,
    parameter int PFX_LG   = 13,
    parameter int CODE_W   = 4,
    parameter int CODE_DEF = 10
) (
    input  logic [1:0]         order,
    input  logic [PARAM_W-1:0] param,
    output logic [PARAM_W-1:0] eff_addr,
    output logic [LEN_W-1:0]   eff_len,
    output logic               misaligned
);
    import spc_pkg::*;

    localparam int LG_W = $clog2(LEN_W);
    localparam logic [PARAM_W-1:0] LIMIT     = (PARAM_W'(1) << ADDR_TOP) - PARAM_W'(1);
    localparam logic [PARAM_W-1:0] STS_MASK  = LIMIT & ~((PARAM_W'(1) << STS_LG) - PARAM_W'(1));
    localparam logic [PARAM_W-1:0] PFX_MASK  = LIMIT & ~((PARAM_W'(1) << PFX_LG) - PARAM_W'(1));
    localparam logic [PARAM_W-1:0] CODE_MASK = (PARAM_W'(1) << CODE_W) - PARAM_W'(1);

    logic [CODE_W-1:0] code;
    logic [LG_W-1:0]   len_lg;

    // Select address mask and log2 length per order.
    always_comb begin
        code = param[CODE_W-1:0];
        case (op_e'(order))
            OP_STORE_AT: begin
                eff_addr = param & STS_MASK;
                len_lg   = LG_W'(STS_LG);
            end
            OP_STORE_EXTRA: begin
                eff_addr = param & ~CODE_MASK;
                len_lg   = (code == '0) ? LG_W'(CODE_DEF) : LG_W'(code);
            end
            OP_SET_PFX: begin
                eff_addr = param & PFX_MASK;
                len_lg   = LG_W'(PFX_LG);
            end
            default: begin
                eff_addr = '0;
                len_lg   = '0;
            end
        endcase
    end

    // Length from its log2 and the alignment test against it.
    always_comb begin
        eff_len    = LEN_W'(1) << len_lg;
        misaligned = |(eff_addr[LEN_W-1:0] & (eff_len - LEN_W'(1)));
    end
endmodule

// File: rtl/spc_rule_eval.sv
// Applies the per-order checks in their fixed precedence and returns the
// first failing status. Assumes misaligned is valid only for extended status.
module spc_rule_eval #(
    parameter int CODE_W = 4,
    parameter int GS_MIN = 10,
    parameter int GS_MAX = 12
) (
    input  logic [1:0]        order,
    input  logic [CODE_W-1:0] code,
    input  logic              stopped,
    input  logic              feat_vec,
    input  logic              feat_gs,
    input  logic              mem_ok,
    input  logic              misaligned,
    output logic [1:0]        status
);
    import spc_pkg::*;

    logic code_legal;
    st_e  st;

    // Legal length codes depend on the guarded-storage feature.
    always_comb begin
        code_legal = (code == '0) ||
                     (feat_gs && (code >= CODE_W'(GS_MIN)) && (code <= CODE_W'(GS_MAX)));
    end

    // Ordered rule chain per order type.
    always_comb begin
        case (op_e'(order))
            OP_STORE_AT: begin
                if (!stopped)      st = ST_BAD_STATE;
                else if (!mem_ok)  st = ST_BAD_PARAM;
                else               st = ST_ACCEPT;
            end
            OP_STORE_EXTRA: begin
                if (!(feat_vec || feat_gs)) st = ST_BAD_ORDER;
                else if (!stopped)          st = ST_BAD_STATE;
                else if (misaligned)        st = ST_BAD_PARAM;
                else if (!code_legal)       st = ST_BAD_PARAM;
                else if (!mem_ok)           st = ST_BAD_PARAM;
                else                        st = ST_ACCEPT;
            end
            OP_SET_PFX: begin
                if (!mem_ok)       st = ST_BAD_PARAM;
                else if (!stopped) st = ST_BAD_STATE;
                else               st = ST_ACCEPT;
            end
            default:               st = ST_BAD_ORDER;
        endcase
        status = st;
    end
endmodule

// File: rtl/status_param_check.sv
// Top of the status-store parameter validator: combinational address and
// rule stages followed by one result register. Assumes mem_ok answers for
// the range derived from the same cycle's operand.
module status_param_check #(
    parameter int PARAM_W  = 64,
    parameter int LEN_W    = 16,
    parameter int ADDR_TOP = 31,
    parameter int STS_LG   = 9,
    parameter int PFX_LG   = 13,
    parameter int CODE_W   = 4,
    parameter int CODE_DEF = 10,
    parameter int GS_MIN   = 10,
    parameter int GS_MAX   = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [1:0]         in_order,
    input  logic [PARAM_W-1:0] in_param,
    input  logic               tgt_stopped,
    input  logic               feat_vec,
    input  logic               feat_gs,
    input  logic               mem_ok,
    output logic               res_valid,
    output logic [1:0]         res_status,
    output logic [PARAM_W-1:0] res_addr,
    output logic [LEN_W-1:0]   res_len,
    output logic               res_req
);
    logic [PARAM_W-1:0] nxt_addr;
    logic [LEN_W-1:0]   nxt_len;
    logic               nxt_misal;
    logic [1:0]         nxt_status;

    spc_addr_gen #(
        .PARAM_W(PARAM_W), .LEN_W(LEN_W), .ADDR_TOP(ADDR_TOP),
        .STS_LG(STS_LG), .PFX_LG(PFX_LG), .CODE_W(CODE_W), .CODE_DEF(CODE_DEF)
    ) u_addr (
        .order(in_order), .param(in_param),
        .eff_addr(nxt_addr), .eff_len(nxt_len), .misaligned(nxt_misal)
    );

    spc_rule_eval #(
        .CODE_W(CODE_W), .GS_MIN(GS_MIN), .GS_MAX(GS_MAX)
    ) u_rules (
        .order(in_order), .code(in_param[CODE_W-1:0]), .stopped(tgt_stopped),
        .feat_vec(feat_vec), .feat_gs(feat_gs), .mem_ok(mem_ok),
        .misaligned(nxt_misal), .status(nxt_status)
    );

    // Register the result one cycle after a valid order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_req    <= 1'b0;
            res_status <= '0;
            res_addr   <= '0;
            res_len    <= '0;
        end else begin
            res_valid <= in_valid;
            res_req   <= in_valid && (nxt_status == spc_pkg::ST_ACCEPT);
            if (in_valid) begin
                res_status <= nxt_status;
                res_addr   <= nxt_addr;
                res_len    <= nxt_len;
            end
        end
    end
endmodule

// File: rtl/status_param_check_sva.sv
// Property checker for status_param_check, bound to every instance.
module status_param_check_sva #(
    parameter int PARAM_W = 64,
    parameter int LEN_W   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [1:0]         in_order,
    input logic [PARAM_W-1:0] in_param,
    input logic               tgt_stopped,
    input logic               feat_vec,
    input logic               feat_gs,
    input logic               mem_ok,
    input logic               res_valid,
    input logic [1:0]         res_status,
    input logic [PARAM_W-1:0] res_addr,
    input logic [LEN_W-1:0]   res_len,
    input logic               res_req
);
    // R1
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);
    // R1
    idle_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);
    // R10
    req_only_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_req |-> (res_valid && res_status == 2'd0));
    // R5
    no_feature_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_order == 2'd1 && !feat_vec && !feat_gs) |=> res_status == 2'd1);
    // R3
    store_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_order == 2'd0 && !tgt_stopped) |=> res_status == 2'd2);
    // R9
    prefix_range_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_order == 2'd2 && !mem_ok) |=> (res_status == 2'd3 && !res_req));
    // R10
    rsvd_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_order == 2'd3) |=> (res_status == 2'd1 && !res_req));
    // R9
    prefix_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_order == 2'd2) |=> res_len == LEN_W'(8192));
endmodule

bind status_param_check status_param_check_sva #(
    .PARAM_W(PARAM_W), .LEN_W(LEN_W)
) u_sva (.*);

// File: tb/status_param_check_test.sv
module status_param_check_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_order = '0;
    logic [63:0] in_param = '0;
    logic        tgt_stopped = 1'b0;
    logic        feat_vec = 1'b0;
    logic        feat_gs = 1'b0;
    logic        mem_ok = 1'b0;
    logic        res_valid;
    logic [1:0]  res_status;
    logic [63:0] res_addr;
    logic [15:0] res_len;
    logic        res_req;

    int n_checks = 0;
    int n_fails  = 0;

    status_param_check uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_order(in_order),
        .in_param(in_param), .tgt_stopped(tgt_stopped), .feat_vec(feat_vec),
        .feat_gs(feat_gs), .mem_ok(mem_ok), .res_valid(res_valid),
        .res_status(res_status), .res_addr(res_addr), .res_len(res_len),
        .res_req(res_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        report();
        $finish;
    end

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Expected outcome per the requirements.
    task automatic model(input logic [1:0] op, input logic [63:0] p,
                         input logic st, input logic fv, input logic fg, input logic mok,
                         output logic [1:0] est, output logic [63:0] ea,
                         output logic [15:0] el, output string stag, output string atag);
        logic [3:0] code;
        int lg;
        code = p[3:0];
        case (op)
            2'd0: begin
                ea = p & 64'h7FFF_FE00; el = 16'd512; atag = "R2"; stag = "R3";
                est = !st ? 2'd2 : (!mok ? 2'd3 : 2'd0);
            end
            2'd1: begin
                ea = p & ~64'hF; atag = "R4";
                lg = (code == 4'd0) ? 10 : int'(code);
                el = 16'(32'd1 << lg);
                if (!(fv || fg))                  begin est = 2'd1; stag = "R5"; end
                else if (!st)                     begin est = 2'd2; stag = "R6"; end
                else if ((ea % 64'(el)) != 0)     begin est = 2'd3; stag = "R7"; end
                else if (!(code == 4'd0 || (fg && (code == 4'd10 || code == 4'd11 || code == 4'd12))))
                                                  begin est = 2'd3; stag = "R8"; end
                else if (!mok)                    begin est = 2'd3; stag = "R3"; end
                else                              begin est = 2'd0; stag = "R8"; end
            end
            2'd2: begin
                ea = p & 64'h7FFF_E000; el = 16'd8192; atag = "R9"; stag = "R9";
                est = !mok ? 2'd3 : (!st ? 2'd2 : 2'd0);
            end
            default: begin
                ea = '0; el = 16'd1; atag = "R10"; stag = "R10"; est = 2'd1;
            end
        endcase
    endtask

    // Drive one order (called at a falling edge), check one cycle later.
    task automatic run_one(input logic [1:0] op, input logic [63:0] p,
                           input logic st, input logic fv, input logic fg, input logic mok);
        logic [1:0]  est;
        logic [63:0] ea;
        logic [15:0] el;
        string stag, atag;
        in_valid = 1'b1; in_order = op; in_param = p;
        tgt_stopped = st; feat_vec = fv; feat_gs = fg; mem_ok = mok;
        model(op, p, st, fv, fg, mok, est, ea, el, stag, atag);
        @(negedge clk);
        check("R1", "valid", 64'(res_valid), 64'd1);
        check(stag, "status", 64'(res_status), 64'(est));
        check("R10", "req", 64'(res_req), 64'(est == 2'd0));
        check(atag, "addr", res_addr, ea);
        check(atag, "len", 64'(res_len), 64'(el));
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11", "valid", 64'(res_valid), 64'd0);
        check("R11", "req", 64'(res_req), 64'd0);
        check("R11", "status", 64'(res_status), 64'd0);
        check("R11", "addr", res_addr, 64'd0);
        check("R11", "len", 64'(res_len), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corners
        run_one(2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 0, 1);     // R2 accept
        run_one(2'd0, 64'h1234_5678_9ABC_DEF0, 0, 0, 0, 1);     // R3 not stopped
        run_one(2'd0, 64'h0000_0000_0000_0200, 1, 0, 0, 0);     // R3 store fails
        run_one(2'd1, 64'h0000_0000_0000_0400, 0, 0, 0, 1);     // R5
        run_one(2'd1, 64'h0000_0000_0000_0400, 0, 1, 0, 1);     // R6
        run_one(2'd1, 64'h0000_0000_0000_0400, 1, 1, 0, 1);     // R4 accept 1024
        run_one(2'd1, 64'h0000_0000_0000_0200, 1, 1, 0, 1);     // R7
        run_one(2'd1, 64'h1000_0000_0000_080B, 1, 1, 0, 1);     // R8 no GS
        run_one(2'd1, 64'h1000_0000_0000_080B, 1, 0, 1, 1);     // R8 GS code 11
        run_one(2'd1, 64'h0000_0000_0000_100C, 1, 0, 1, 1);     // R8 code 12
        run_one(2'd1, 64'h0000_0000_0000_200D, 1, 1, 1, 1);     // R8 code 13
        run_one(2'd1, 64'h0000_0000_0000_040A, 1, 1, 1, 0);     // R3 store fails
        run_one(2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0);     // R9 range first
        run_one(2'd2, 64'h0000_0000_0001_2345, 0, 0, 0, 1);     // R9 not stopped
        run_one(2'd2, 64'h0000_0000_0001_2345, 1, 0, 0, 1);     // R9 accept
        run_one(2'd3, 64'h0000_0000_0000_0000, 1, 1, 1, 1);     // R10 unused order

        // R1 R10: idle cycle drops valid and request
        in_valid = 1'b0;
        @(negedge clk);
        check("R1", "idle valid", 64'(res_valid), 64'd0);
        check("R10", "idle req", 64'(res_req), 64'd0);

        // Seeded random mix
        for (int i = 0; i < 400; i++) begin
            logic [63:0] p;
            logic [3:0]  pick;
            p = {$urandom, $urandom};
            if ($urandom % 2 == 0) begin
                pick = 4'($urandom % 4);
                p[3:0] = (pick == 0) ? 4'd0 : 4'(9 + pick);
            end
            if ($urandom % 2 == 0) p[14:4] = '0;
            run_one(2'($urandom % 4), p, 1'($urandom), 1'($urandom),
                    1'($urandom), 1'($urandom));
        end

        in_valid = 1'b0;
        @(negedge clk);
        report();
        $finish;
    end
endmodule